// File: doc/BRIEF.md
# Infrared SIR Pulse Codec with Test Routing

This block sits between a UART's serial bit stream and an infrared transceiver. On the way out it turns every zero bit of the transmit line into one short light pulse. On the way in it turns each qualified pulse from the receiver back into a full bit cell of logic zero on the UART receive line. It also holds the plain serial pin at the marking level, and it masks the plain receive and modem status pins while infrared operation is selected.

The pulse width has two settings. In normal mode the pulse lasts three sixteenths of a bit, measured with the same 16x baud enable that the UART uses. In low-power mode the pulse lasts three periods of a separate 16x reference tick, whatever the baud rate is. Three loopback routings support system test: infrared output back to the decoder, UART transmit back to UART receive, and modem control back to modem status.

All mode inputs take effect only while the UART is active. When the UART is switched off, the character in flight is allowed to finish first.

Top module: `irda_sir_codec`

## Requirements
- R1: In normal mode (lp_mode_i=0), a zero on uart_txd_i makes ir_drive_o high for exactly 3 baud16 tick periods. The pulse starts after the tick at phase 7 of the bit cell. Phase 0 is the baud16 tick at which the change on uart_txd_i is sampled. Each tick adds one to the phase, and the phase wraps after 15. A line held at one makes no pulse.
- R2: In low-power mode (lp_mode_i=1), the pulse waits for the first lp16_tick_i after the phase-7 trigger. It then lasts exactly 3 lp16_tick_i periods, independent of the baud16 rate.
- R3: While infrared operation is off (sir_en_i=0 or UART inactive), ir_drive_o stays low and ir_rx_i has no effect on uart_rxd_o.
- R4: While infrared operation is on, txd_pin_o is held high. rxd_pin_i has no effect on uart_rxd_o. mdm_sts_o reads all zeros unless modem loopback applies.
- R5: A low on ir_rx_i passes a synchroniser of SYNC_STAGES flops. If it is still low at the next baud16 tick after its falling edge is seen, uart_rxd_o goes low for 16 baud16 tick periods. A low that ends before that tick is discarded.
- R6: With lpbk_en_i, sir_en_i and test_ovr_i all set, the decoder is fed from the inverse of ir_drive_o, and ir_rx_i is ignored.
- R7: With lpbk_en_i set and test_ovr_i clear, uart_rxd_o follows uart_txd_i directly, and txd_pin_o is held high.
- R8: While the UART is active and lpbk_en_i is set, mdm_sts_o equals mdm_ctl_i in both infrared and plain mode.
- R9: The UART becomes active one clock after uart_en_i rises. After uart_en_i falls, it stays active while char_active_i is high, and it goes inactive one clock after both are low. While inactive, ir_drive_o is low, txd_pin_o and uart_rxd_o are high, and mdm_sts_o equals mdm_sts_pin_i.
- R10: During reset the block is inactive: ir_drive_o is low, and txd_pin_o and uart_rxd_o are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uart_en_i | input | 1 | UART enable |
| char_active_i | input | 1 | High while the UART has a character in flight |
| sir_en_i | input | 1 | Selects infrared operation |
| lp_mode_i | input | 1 | Selects low-power pulse timing |
| lpbk_en_i | input | 1 | Loopback enable |
| test_ovr_i | input | 1 | Test override that selects the infrared loop |
| baud16_tick_i | input | 1 | One-clock enable at 16x the baud rate |
| lp16_tick_i | input | 1 | One-clock low-power reference tick |
| uart_txd_i | input | 1 | Serial transmit line from the UART |
| uart_rxd_o | output | 1 | Serial receive line to the UART |
| txd_pin_o | output | 1 | Plain serial transmit pin |
| rxd_pin_i | input | 1 | Plain serial receive pin |
| ir_drive_o | output | 1 | Infrared emitter drive, high means light |
| ir_rx_i | input | 1 | Infrared receiver output, low means light |
| mdm_ctl_i | input | MDM_W | Modem control outputs of the UART |
| mdm_sts_pin_i | input | MDM_W | Modem status pins |
| mdm_sts_o | output | MDM_W | Modem status to the UART |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, a 3-tick pulse starting at phase 7, a two-flop synchroniser and a 4-bit modem group. It drives a baud16 tick every 4 clocks and a low-power tick every 7 clocks. With these rates a normal pulse is 12 clocks, a low-power pulse is 21 clocks and a decoded zero is 64 clocks, so each width can be measured to the exact clock. The start of a pulse can also be checked against its bit cell. The fast tick rate lets a one-clock glitch fall between two ticks, which exercises the path that discards it.

// File: rtl/irda_pkg.sv
package irda_pkg;
   typedef enum logic [1:0] {
      ENC_IDLE  = 2'd0,
      ENC_ARM   = 2'd1,
      ENC_PULSE = 2'd2
   } enc_state_e;
endpackage

// File: rtl/irda_sir_enc.sv
module irda_sir_enc #(
   parameter int PH_W        = 4,
   parameter int PULSE_TICKS = 3,
   parameter int PULSE_START = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   input  logic lp_tick_i,
   input  logic lp_mode_i,
   input  logic txd_i,
   output logic pulse_o
);
   import irda_pkg::*;

   localparam int W_W = $clog2(PULSE_TICKS + 1);

   enc_state_e      st;
   logic [PH_W-1:0] ph;
   logic [PH_W-1:0] cur_ph;
   logic [W_W-1:0]  w;
   logic            txd_q;
   logic            fire;
   logic            step;

   // a sampled change on the line restarts the bit cell at phase 0
   always_comb begin
      cur_ph = (txd_i != txd_q) ? '0 : ph;
      fire   = tick_i && !txd_i && (cur_ph == PH_W'(PULSE_START));
      step   = lp_mode_i ? lp_tick_i : tick_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ENC_IDLE;
         ph      <= '0;
         txd_q   <= 1'b1;
         w       <= '0;
         pulse_o <= 1'b0;
      end else if (!run_i) begin
         st      <= ENC_IDLE;
         ph      <= '0;
         txd_q   <= 1'b1;
         w       <= '0;
         pulse_o <= 1'b0;
      end else begin
         if (tick_i) begin
            txd_q <= txd_i;
            ph    <= PH_W'(cur_ph + 1'b1);
         end
         case (st)
            ENC_IDLE: begin
               if (fire) begin
                  if (lp_mode_i) begin
                     st <= ENC_ARM;
                  end else begin
                     st      <= ENC_PULSE;
                     pulse_o <= 1'b1;
                     w       <= '0;
                  end
               end
            end
            ENC_ARM: begin
               if (lp_tick_i) begin
                  st      <= ENC_PULSE;
                  pulse_o <= 1'b1;
                  w       <= '0;
               end
            end
            ENC_PULSE: begin
               if (step) begin
                  if (w == W_W'(PULSE_TICKS - 1)) begin
                     st      <= ENC_IDLE;
                     pulse_o <= 1'b0;
                  end else begin
                     w <= W_W'(w + 1'b1);
                  end
               end
            end
            default: st <= ENC_IDLE;
         endcase
      end
   end

   // R1
   norm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pulse_o) && !lp_mode_i) |-> ($past(tick_i) && !$past(txd_i)));

   // R2
   lp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pulse_o) && lp_mode_i) |-> $past(lp_tick_i));
endmodule

// File: rtl/irda_sir_dec.sv
module irda_sir_dec #(
   parameter int PH_W        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   input  logic din_i,
   output logic rxd_o
);
   localparam int CELL   = 2 ** PH_W;
   localparam int HOLD_W = PH_W + 1;

   logic [SYNC_STAGES-1:0] sr;
   logic                   s;
   logic                   s_q;
   logic                   chk;
   logic [HOLD_W-1:0]      hold;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[g] <= 1'b1;
            else        sr[g] <= din_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[g] <= 1'b1;
            else        sr[g] <= sr[g-1];
         end
      end
   end

   assign s = sr[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q  <= 1'b1;
         chk  <= 1'b0;
         hold <= '0;
      end else if (!run_i) begin
         s_q  <= 1'b1;
         chk  <= 1'b0;
         hold <= '0;
      end else begin
         s_q <= s;
         if (chk && s) begin
            chk <= 1'b0;
         end else if (chk && tick_i) begin
            chk  <= 1'b0;
            hold <= HOLD_W'(CELL);
         end else if (s_q && !s) begin
            chk <= 1'b1;
         end
         if (!(chk && !s && tick_i) && tick_i && hold != '0)
            hold <= HOLD_W'(hold - 1'b1);
      end
   end

   assign rxd_o = (hold == '0);

   // R5
   rx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rxd_o) |-> $past(tick_i));
endmodule

// File: rtl/irda_route.sv
module irda_route #(
   parameter int MDM_W = 4
) (
   input  logic             act_i,
   input  logic             sir_en_i,
   input  logic             lpbk_en_i,
   input  logic             test_ovr_i,
   input  logic             uart_txd_i,
   input  logic             rxd_pin_i,
   input  logic             ir_rx_i,
   input  logic             ir_pulse_i,
   input  logic             dec_rxd_i,
   input  logic [MDM_W-1:0] mdm_ctl_i,
   input  logic [MDM_W-1:0] mdm_pin_i,
   output logic             sir_run_o,
   output logic             dec_in_o,
   output logic             txd_pin_o,
   output logic             uart_rxd_o,
   output logic [MDM_W-1:0] mdm_sts_o
);
   logic ir_loop;
   logic txd_loop;

   always_comb begin
      sir_run_o = act_i && sir_en_i;
      ir_loop   = act_i && lpbk_en_i && sir_en_i && test_ovr_i;
      txd_loop  = act_i && lpbk_en_i && !test_ovr_i;
      dec_in_o  = ir_loop ? !ir_pulse_i : ir_rx_i;
      txd_pin_o = (act_i && !sir_en_i && !lpbk_en_i) ? uart_txd_i : 1'b1;

      if (!act_i)        uart_rxd_o = 1'b1;
      else if (txd_loop) uart_rxd_o = uart_txd_i;
      else if (sir_en_i) uart_rxd_o = dec_rxd_i;
      else               uart_rxd_o = rxd_pin_i;

      if (act_i && lpbk_en_i)     mdm_sts_o = mdm_ctl_i;
      else if (act_i && sir_en_i) mdm_sts_o = '0;
      else                        mdm_sts_o = mdm_pin_i;
   end
endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec #(
   parameter int PH_W        = 4,
   parameter int PULSE_TICKS = 3,
   parameter int PULSE_START = 7,
   parameter int SYNC_STAGES = 2,
   parameter int MDM_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uart_en_i,
   input  logic             char_active_i,
   input  logic             sir_en_i,
   input  logic             lp_mode_i,
   input  logic             lpbk_en_i,
   input  logic             test_ovr_i,
   input  logic             baud16_tick_i,
   input  logic             lp16_tick_i,
   input  logic             uart_txd_i,
   output logic             uart_rxd_o,
   output logic             txd_pin_o,
   input  logic             rxd_pin_i,
   output logic             ir_drive_o,
   input  logic             ir_rx_i,
   input  logic [MDM_W-1:0] mdm_ctl_i,
   input  logic [MDM_W-1:0] mdm_sts_pin_i,
   output logic [MDM_W-1:0] mdm_sts_o
);
   if (PULSE_START + PULSE_TICKS > 2 ** PH_W) begin : g_bad_pulse
      $error("pulse does not fit in one bit cell");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchroniser needs at least two stages");
   end
   if (MDM_W < 1) begin : g_bad_mdm
      $error("modem group must be at least one bit wide");
   end

   logic en_q;
   logic sir_run;
   logic dec_in;
   logic dec_rxd;

   // the active state drains the character in flight before dropping
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= 1'b0;
      else if (uart_en_i) en_q <= 1'b1;
      else                en_q <= en_q && char_active_i;
   end

   irda_route #(.MDM_W(MDM_W)) u_route (
      .act_i      (en_q),
      .sir_en_i   (sir_en_i),
      .lpbk_en_i  (lpbk_en_i),
      .test_ovr_i (test_ovr_i),
      .uart_txd_i (uart_txd_i),
      .rxd_pin_i  (rxd_pin_i),
      .ir_rx_i    (ir_rx_i),
      .ir_pulse_i (ir_drive_o),
      .dec_rxd_i  (dec_rxd),
      .mdm_ctl_i  (mdm_ctl_i),
      .mdm_pin_i  (mdm_sts_pin_i),
      .sir_run_o  (sir_run),
      .dec_in_o   (dec_in),
      .txd_pin_o  (txd_pin_o),
      .uart_rxd_o (uart_rxd_o),
      .mdm_sts_o  (mdm_sts_o)
   );

   irda_sir_enc #(
      .PH_W        (PH_W),
      .PULSE_TICKS (PULSE_TICKS),
      .PULSE_START (PULSE_START)
   ) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (sir_run),
      .tick_i    (baud16_tick_i),
      .lp_tick_i (lp16_tick_i),
      .lp_mode_i (lp_mode_i),
      .txd_i     (uart_txd_i),
      .pulse_o   (ir_drive_o)
   );

   irda_sir_dec #(
      .PH_W        (PH_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (sir_run),
      .tick_i (baud16_tick_i),
      .din_i  (dec_in),
      .rxd_o  (dec_rxd)
   );

   // R4
   mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ir_drive_o |-> txd_pin_o);

   // R9
   drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !uart_en_i && char_active_i) |=> (txd_pin_o == (sir_en_i || lpbk_en_i || uart_txd_i)));
endmodule

// File: tb/sim_irda_sir_codec.sv
module sim_irda_sir_codec;
   localparam int MW = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          uart_en = 1'b0, char_active = 1'b0;
   logic          sir_en = 1'b0, lp_mode = 1'b0, lpbk = 1'b0, tst = 1'b0;
   logic          baud_tick = 1'b0, lp_tick = 1'b0;
   logic          txd = 1'b1, rxd_pin = 1'b1, ir_rx = 1'b1;
   logic [MW-1:0] mdm_ctl = '0, mdm_pin = '0;
   logic          uart_rxd, txd_pin, ir_drive;
   logic [MW-1:0] mdm_sts;

   int  tc = 0, lc = 0;
   int  vec = 0, miss = 0;
   bit  done = 1'b0;

   irda_sir_codec u0 (
      .clk (clk), .rst_n (rst_n), .uart_en_i (uart_en), .char_active_i (char_active),
      .sir_en_i (sir_en), .lp_mode_i (lp_mode), .lpbk_en_i (lpbk), .test_ovr_i (tst),
      .baud16_tick_i (baud_tick), .lp16_tick_i (lp_tick), .uart_txd_i (txd),
      .uart_rxd_o (uart_rxd), .txd_pin_o (txd_pin), .rxd_pin_i (rxd_pin),
      .ir_drive_o (ir_drive), .ir_rx_i (ir_rx), .mdm_ctl_i (mdm_ctl),
      .mdm_sts_pin_i (mdm_pin), .mdm_sts_o (mdm_sts)
   );

   // baud16 tick every 4 clocks, low-power tick every 7 clocks
   always @(negedge clk) begin
      tc        <= (tc == 3) ? 0 : tc + 1;
      baud_tick <= (tc == 2);
      lc        <= (lc == 6) ? 0 : lc + 1;
      lp_tick   <= (lc == 5);
   end

   // bits: en sir lb tst txd rxp irx | mc[4] | mp[4] | txdpin rxd | ms[4]
   localparam logic [20:0] VEC [12] = '{
      21'b1_0_0_0_0_0_1_1010_0101_0_0_0101,
      21'b1_0_0_0_1_1_1_1010_0101_1_1_0101,
      21'b1_1_0_0_1_0_1_1010_0101_1_1_0000,
      21'b1_1_0_0_0_1_1_1010_0110_1_1_0000,
      21'b1_0_1_0_0_1_1_1010_0101_1_0_1010,
      21'b1_0_1_0_1_0_1_1010_0101_1_1_1010,
      21'b1_1_1_0_0_1_1_0011_0101_1_0_0011,
      21'b1_1_1_1_1_0_0_1100_0101_1_1_1100,
      21'b1_0_1_1_0_0_1_1001_0110_1_0_1001,
      21'b1_1_0_0_1_1_0_1010_0101_1_0_0000,
      21'b0_1_0_0_0_0_0_1010_0101_1_1_0101,
      21'b0_0_1_0_0_0_1_1010_0011_1_1_0011
   };
   localparam string TAG [12] = '{
      "R9 plain", "R9 plain", "R4", "R4", "R7 R8", "R7 R8",
      "R7 R8", "R6 R8", "R8", "R5", "R3 R9", "R9 R8"
   };

   task automatic chk(input string r, input int act, input int exp);
      vec++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s: got %0d expected %0d", r, act, exp);
      end
   endtask

   task automatic start(input logic s, input logic lp, input logic lb, input logic t);
      @(negedge clk);
      rst_n = 1'b0; sir_en = s; lp_mode = lp; lpbk = lb; tst = t;
      uart_en = 1'b1; char_active = 1'b0; txd = 1'b1; ir_rx = 1'b1; rxd_pin = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic align();
      do @(posedge clk); while (!baud_tick);
      @(negedge clk);
   endtask

   // drive txd low for nbits cells from an aligned point; measure ir_drive
   task automatic send_zero(input int nbits, input int n, output int first, output int cnt);
      first = -1; cnt = 0;
      align();
      txd = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (i == 64 * nbits) txd = 1'b1;
         if (ir_drive) begin
            cnt++;
            if (first < 0) first = i;
         end
         @(negedge clk);
      end
   endtask

   task automatic count_rx_low(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         if (!uart_rxd) cnt++;
         @(negedge clk);
      end
   endtask

   initial begin
      int first, cnt;

      // R10: reset state
      uart_en = 1'b1; sir_en = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 ir_drive", ir_drive, 0);
      chk("R10 txd_pin", txd_pin, 1);
      chk("R10 uart_rxd", uart_rxd, 1);

      // routing vectors
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         rst_n = 1'b0;
         {uart_en, sir_en, lpbk, tst, txd, rxd_pin, ir_rx} = VEC[k][20:14];
         mdm_ctl = VEC[k][13:10]; mdm_pin = VEC[k][9:6];
         lp_mode = 1'b0; char_active = 1'b0;
         repeat (2) @(negedge clk);
         rst_n = 1'b1;
         repeat (16) @(negedge clk);
         chk(TAG[k], txd_pin, int'(VEC[k][5]));
         chk(TAG[k], uart_rxd, int'(VEC[k][4]));
         chk(TAG[k], int'(mdm_sts), int'(VEC[k][3:0]));
         chk("R3 no pulse in routing row", ir_drive, 0);
      end

      // R1: marking line gives no pulse, zero bit gives a centred 3-tick pulse
      start(1'b1, 1'b0, 1'b0, 1'b0);
      cnt = 0;
      for (int i = 0; i < 100; i++) begin
         if (ir_drive) cnt++;
         @(negedge clk);
      end
      chk("R1 ones make no pulse", cnt, 0);
      send_zero(1, 120, first, cnt);
      chk("R1 pulse start", first, 32);
      chk("R1 pulse width", cnt, 12);
      send_zero(2, 200, first, cnt);
      chk("R1 two zero bits", cnt, 24);
      chk("R4 pin marks during IR", txd_pin, 1);

      // R2: low-power width
      start(1'b1, 1'b1, 1'b0, 1'b0);
      send_zero(1, 120, first, cnt);
      chk("R2 lp pulse width", cnt, 21);
      chk("R2 lp start window", int'(first >= 33 && first <= 39), 1);

      // R3: encoder off when infrared is not selected
      start(1'b0, 1'b0, 1'b0, 1'b0);
      ir_rx = 1'b0;
      send_zero(1, 100, first, cnt);
      chk("R3 no pulse when off", cnt, 0);
      chk("R3 ir_rx ignored", uart_rxd, 1);

      // R5: one-clock glitch rejected
      start(1'b1, 1'b0, 1'b0, 1'b0);
      align();
      ir_rx = 1'b0;
      @(negedge clk);
      ir_rx = 1'b1;
      count_rx_low(80, cnt);
      chk("R5 glitch rejected", cnt, 0);

      // R5: qualified pulse gives one full bit cell of zero
      align();
      cnt = 0;
      for (int i = 0; i < 120; i++) begin
         if (i == 0) ir_rx = 1'b0;
         if (i == 6) ir_rx = 1'b1;
         if (!uart_rxd) cnt++;
         @(negedge clk);
      end
      chk("R5 decoded zero length", cnt, 64);

      // R6: infrared loop, external receiver held active but ignored
      start(1'b1, 1'b0, 1'b1, 1'b1);
      ir_rx = 1'b0;
      repeat (20) @(negedge clk);
      chk("R6 external ir ignored", uart_rxd, 1);
      align();
      txd = 1'b0;
      cnt = 0;
      for (int i = 0; i < 160; i++) begin
         if (i == 64) txd = 1'b1;
         if (!uart_rxd) cnt++;
         @(negedge clk);
      end
      chk("R6 looped zero length", cnt, 64);

      // R9: disable drains the character in flight
      start(1'b0, 1'b0, 1'b0, 1'b0);
      char_active = 1'b1; txd = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 active plain tx", txd_pin, 0);
      uart_en = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9 held while char active", txd_pin, 0);
      char_active = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 inactive after drain", txd_pin, 1);
      chk("R9 rxd idle when inactive", uart_rxd, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         miss++;
         $display("FAIL watchdog R10 flow: got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
         $finish;
      end
   end
endmodule